// File: doc/BRIEF.md
# Multirate Dual-Path Duty Compensator

This block closes the voltage loop of a fixed-frequency digital PWM power stage. It receives signed, quantised output-voltage error samples at N times the switching rate, together with a strobe that marks the first sample of each switching period. It returns a duty-cycle command that is refreshed on every sample, so a correction can reach the modulator several times inside one switching period. The switching period itself never changes.

Two paths add up to form the command. The slow path is a proportional-integral controller that acts once per period, on the strobed sample only. The fast path acts on every sample, after a ripple filter that subtracts the sample taken at the same phase one period earlier. This filter removes anything that repeats each period and passes steps at once. At each period start, the fast term is rebuilt from the command that was actually issued minus the slow contribution, scaled by a residual factor. In this way a fast correction is taken back over the next period or periods instead of winding up. The loop gain, the residual, the oversampling ratio and the duty ceiling are register inputs. They are captured only at a period start.

Top module: `mr_pwm_comp`

## Requirements
- R1: While `rst` is high, `duty_cmd` is 0 and `duty_vld` is 0. Reset also clears the sample history, the integrator, the fast term and the captured configuration. The captured configuration then holds gain 0, residual 0, ratio code 1 and ceiling 0. In the first period after reset, each ripple-filter output therefore equals the sample itself.
- R2: `duty_vld` is high in exactly the cycle after each cycle in which `smp_vld` is high. `duty_cmd` changes only in such cycles.
- R3: The fast-path input is the sample minus the sample stored at the same phase one period earlier. The phase is 0 on a tick with `per_start` high and rises by one on each other tick. An error pattern that repeats every period adds nothing to the fast term. A step passes through on the tick where it occurs.
- R4: Each tick adds (gain × filtered error) >>> 4 to the fast term. Gain is unsigned with 4 fraction bits and the shift is arithmetic. The result appears on `duty_cmd` in the cycle right after that tick, without waiting for a period start.
- R5: On a tick with `per_start` high, the integrator adds the sample. The slow output becomes ((gain × sample) >>> 4) + (integrator >>> 2). Between such ticks, both values hold.
- R6: The integrator saturates at 32767 and at −32768.
- R7: On a tick with `per_start` high, the fast term restarts from ((previous `duty_cmd` − previous slow output) × residual) >>> 8, and that tick's increment is added to it. A residual of 0 cancels the earlier fast correction in full.
- R8: `duty_cmd` equals the sum of the slow output and the fast term, clamped to the range 0 to the captured ceiling.
- R9: Gain, residual, ratio code and ceiling are captured only on a tick with `per_start` high. They apply from that tick onward. Changes made at other times have no effect until the next such tick.
- R10: The ratio code k sets N = 2^k. Codes below 1 are treated as 1 and codes above 4 are treated as 4. If no strobe arrives, the phase wraps to 0 after N ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Error sample tick (N per switching period) |
| smp_err | input | 12 | Signed error sample |
| per_start | input | 1 | Marks the tick that opens a switching period |
| cfg_gain | input | 8 | Loop gain, unsigned, 4 fraction bits |
| cfg_resid | input | 8 | Residual, decay factor in 1/256 units |
| cfg_nlog2 | input | 3 | log2 of the oversampling ratio |
| cfg_dmax | input | 12 | Duty ceiling |
| duty_cmd | output | 12 | Registered duty-cycle command |
| duty_vld | output | 1 | One-cycle pulse per refreshed command |

## Verification
The bench builds the block with its default parameters: 12-bit error and duty, a 16-entry history, a 16-bit integrator and an integral shift of 2. Full-scale errors therefore drive the integrator into its clamp within sixteen periods, and ratio codes from 0 to 4 exercise every history depth along with the clamping of the code. The bench runs a behavioural model in step with the block on every clock. It also sets hand-computed points for the first period after reset, for full cancellation with a residual of 0, for partial decay, for recovery from integrator windup and for both ends of the output clamp.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

  localparam int GAIN_FRAC = 4;
  localparam int RES_FRAC  = 8;

  function automatic logic [2:0] fix_nlog2(input logic [2:0] v, input int maxl);
    if (v == 3'd0) return 3'd1;
    if (int'(v) > maxl) return 3'(maxl);
    return v;
  endfunction

endpackage

// File: rtl/mrc_ripple_filt.sv
module mrc_ripple_filt #(
  parameter int EW = 12,
  parameter int AW = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 bnd,
  input  logic [2:0]           nlog2,
  input  logic signed [EW-1:0] err,
  output logic signed [EW:0]   filt
);

  localparam int DEPTH = 1 << AW;

  logic signed [EW-1:0] hist_mem [DEPTH];
  logic [DEPTH-1:0]     seen_q;
  logic [AW-1:0]        ph_q, idx, nmask, ph_nx;
  logic [AW:0]          nfull;
  logic signed [EW-1:0] prev;

  always_comb begin
    nfull = (AW+1)'(1) << nlog2;
    nmask = AW'(nfull - (AW+1)'(1));
    idx   = bnd ? '0 : (ph_q & nmask);
    prev  = seen_q[idx] ? hist_mem[idx] : '0;
    filt  = (EW+1)'(err) - (EW+1)'(prev);
    ph_nx = (idx + AW'(1)) & nmask;
  end

  // history storage: no reset, so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (tick) hist_mem[idx] <= err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= '0;
      ph_q   <= '0;
    end else if (tick) begin
      seen_q[idx] <= 1'b1;
      ph_q        <= ph_nx;
    end
  end

  // R10: without a strobe the phase wraps after the last slot
  a_r10_phase_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && !bnd && ((ph_q & nmask) == nmask)) |=> (ph_q == '0));

  // R3: a strobed tick always writes slot 0 and moves on to slot 1
  a_r3_strobe_slot0: assert property (@(posedge clk) disable iff (rst)
    (tick && bnd) |=> (ph_q == AW'(1)) && seen_q[0]);

endmodule

// File: rtl/mrc_slow_pi.sv
module mrc_slow_pi #(
  parameter int EW       = 12,
  parameter int IW       = 16,
  parameter int SW       = 22,
  parameter int KI_SHIFT = 2,
  parameter int GF       = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic signed [EW-1:0] err,
  input  logic [7:0]           gain,
  output logic signed [SW-1:0] slow_q,
  output logic signed [SW-1:0] slow_nx
);

  localparam logic signed [IW:0] IMAX = (IW+1)'((2**(IW-1)) - 1);
  localparam logic signed [IW:0] IMIN = -IMAX - (IW+1)'(1);

  logic signed [IW-1:0] integ_q, integ_nx;
  logic signed [IW:0]   isum;
  logic signed [EW+8:0] prod;

  always_comb begin
    isum = (IW+1)'(integ_q) + (IW+1)'(err);
    if (isum > IMAX)      integ_nx = IMAX[IW-1:0];
    else if (isum < IMIN) integ_nx = IMIN[IW-1:0];
    else                  integ_nx = isum[IW-1:0];
    prod    = (EW+9)'($signed({1'b0, gain})) * (EW+9)'(err);
    slow_nx = SW'(prod >>> GF) + SW'(integ_nx >>> KI_SHIFT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_q <= '0;
      slow_q  <= '0;
    end else if (load) begin
      integ_q <= integ_nx;
      slow_q  <= slow_nx;
    end
  end

  // R5: the slow path moves only on a strobed tick
  a_r5_slow_holds: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(slow_q) && $stable(integ_q));

  // R6: a saturated integrator does not wrap further
  a_r6_clamp_high: assert property (@(posedge clk) disable iff (rst)
    (load && (integ_q == IMAX[IW-1:0]) && !err[EW-1]) |=> (integ_q == IMAX[IW-1:0]));

  a_r6_clamp_low: assert property (@(posedge clk) disable iff (rst)
    (load && (integ_q == IMIN[IW-1:0]) && err[EW-1]) |=> (integ_q == IMIN[IW-1:0]));

endmodule

// File: rtl/mrc_fast_path.sv
module mrc_fast_path #(
  parameter int EW = 12,
  parameter int DW = 12,
  parameter int SW = 22,
  parameter int FW = 28,
  parameter int GF = 4,
  parameter int RF = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 bnd,
  input  logic signed [EW:0]   filt,
  input  logic [7:0]           gain,
  input  logic [7:0]           resid,
  input  logic [DW-1:0]        duty_q,
  input  logic signed [SW-1:0] slow_q,
  output logic signed [FW-1:0] fast_nx
);

  localparam int PW = EW + 10;
  localparam int XW = SW + 10;

  logic signed [PW-1:0] prod, inc;
  logic signed [SW:0]   diff;
  logic signed [XW-1:0] decay, base;
  logic signed [FW-1:0] fast_q;

  always_comb begin
    prod    = PW'($signed({1'b0, gain})) * PW'(filt);
    inc     = prod >>> GF;
    // fed-back issued command minus the slow share = fast share actually applied
    diff    = (SW+1)'($signed({1'b0, duty_q})) - (SW+1)'(slow_q);
    decay   = XW'(diff) * XW'($signed({1'b0, resid}));
    base    = decay >>> RF;
    fast_nx = bnd ? (FW'(base) + FW'(inc)) : (fast_q + FW'(inc));
  end

  always_ff @(posedge clk) begin
    if (rst)       fast_q <= '0;
    else if (tick) fast_q <= fast_nx;
  end

  // R7: zero residual with no fresh deviation leaves no fast correction
  a_r7_full_cancel: assert property (@(posedge clk) disable iff (rst)
    (tick && bnd && (resid == 8'd0) && (filt == '0)) |=> (fast_q == '0));

  // R4: the fast term moves only on sample ticks
  a_r4_fast_idle: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(fast_q));

endmodule

// File: rtl/mr_pwm_comp.sv
module mr_pwm_comp #(
  parameter int EW        = 12,
  parameter int DW        = 12,
  parameter int MAXN_LOG2 = 4,
  parameter int IW        = 16,
  parameter int KI_SHIFT  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_vld,
  input  logic signed [EW-1:0] smp_err,
  input  logic                 per_start,
  input  logic [7:0]           cfg_gain,
  input  logic [7:0]           cfg_resid,
  input  logic [2:0]           cfg_nlog2,
  input  logic [DW-1:0]        cfg_dmax,
  output logic [DW-1:0]        duty_cmd,
  output logic                 duty_vld
);
  import mrc_pkg::*;

  localparam int PW = EW + 9;
  localparam int SW = ((PW > IW) ? PW : IW) + 1;
  localparam int FW = SW + MAXN_LOG2 + 2;

  logic                 bnd;
  logic [7:0]           act_gain, act_resid, eff_gain, eff_resid;
  logic [2:0]           act_nlog2, eff_nlog2, fixed_nlog2;
  logic [DW-1:0]        act_dmax, eff_dmax;
  logic signed [EW:0]   filt;
  logic signed [SW-1:0] slow_q, slow_nx, slow_eff;
  logic signed [FW-1:0] fast_nx;
  logic signed [FW:0]   sum, dmax_ext;
  logic [DW-1:0]        duty_nx;

  // configuration shadow: the strobed tick sees the new values directly
  always_comb begin
    bnd         = smp_vld & per_start;
    fixed_nlog2 = fix_nlog2(cfg_nlog2, MAXN_LOG2);
    eff_gain    = bnd ? cfg_gain    : act_gain;
    eff_resid   = bnd ? cfg_resid   : act_resid;
    eff_nlog2   = bnd ? fixed_nlog2 : act_nlog2;
    eff_dmax    = bnd ? cfg_dmax    : act_dmax;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_gain  <= '0;
      act_resid <= '0;
      act_nlog2 <= 3'd1;
      act_dmax  <= '0;
    end else if (bnd) begin
      act_gain  <= cfg_gain;
      act_resid <= cfg_resid;
      act_nlog2 <= fixed_nlog2;
      act_dmax  <= cfg_dmax;
    end
  end

  mrc_ripple_filt #(.EW(EW), .AW(MAXN_LOG2)) u_rip (
    .clk(clk), .rst(rst), .tick(smp_vld), .bnd(bnd),
    .nlog2(eff_nlog2), .err(smp_err), .filt(filt)
  );

  mrc_slow_pi #(.EW(EW), .IW(IW), .SW(SW), .KI_SHIFT(KI_SHIFT), .GF(GAIN_FRAC)) u_slow (
    .clk(clk), .rst(rst), .load(bnd), .err(smp_err), .gain(eff_gain),
    .slow_q(slow_q), .slow_nx(slow_nx)
  );

  mrc_fast_path #(.EW(EW), .DW(DW), .SW(SW), .FW(FW), .GF(GAIN_FRAC), .RF(RES_FRAC)) u_fast (
    .clk(clk), .rst(rst), .tick(smp_vld), .bnd(bnd), .filt(filt),
    .gain(eff_gain), .resid(eff_resid), .duty_q(duty_cmd), .slow_q(slow_q),
    .fast_nx(fast_nx)
  );

  always_comb begin
    slow_eff = bnd ? slow_nx : slow_q;
    sum      = (FW+1)'(slow_eff) + (FW+1)'(fast_nx);
    dmax_ext = (FW+1)'($signed({1'b0, eff_dmax}));
    if (sum < 0)             duty_nx = '0;
    else if (sum > dmax_ext) duty_nx = eff_dmax;
    else                     duty_nx = sum[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_cmd <= '0;
      duty_vld <= 1'b0;
    end else begin
      duty_vld <= smp_vld;
      if (smp_vld) duty_cmd <= duty_nx;
    end
  end

  // R1: reset leaves a zero, invalid command
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (duty_cmd == '0) && !duty_vld);

  // R2: one valid pulse per tick, command frozen otherwise
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> duty_vld);

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> !duty_vld && $stable(duty_cmd));

  // R8: the issued command never exceeds the captured ceiling
  a_r8_duty_ceiling: assert property (@(posedge clk) disable iff (rst)
    duty_vld |-> (duty_cmd <= act_dmax));

  // R9: captured configuration moves only on a strobed tick
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    !bnd |=> $stable(act_gain) && $stable(act_resid) && $stable(act_nlog2) && $stable(act_dmax));

endmodule

// File: tb/sim_mr_pwm_comp.sv
module sim_mr_pwm_comp;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              smp_vld = 1'b0;
  logic signed [11:0] smp_err = '0;
  logic              per_start = 1'b0;
  logic [7:0]        cfg_gain = '0;
  logic [7:0]        cfg_resid = '0;
  logic [2:0]        cfg_nlog2 = 3'd1;
  logic [11:0]       cfg_dmax = '0;
  logic [11:0]       duty_cmd;
  logic              duty_vld;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;  // 50 MHz

  mr_pwm_comp u0 (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_err(smp_err), .per_start(per_start),
    .cfg_gain(cfg_gain), .cfg_resid(cfg_resid), .cfg_nlog2(cfg_nlog2), .cfg_dmax(cfg_dmax),
    .duty_cmd(duty_cmd), .duty_vld(duty_vld)
  );

  // ---------------- behavioural reference ----------------
  int m_hist[16];
  bit m_seen[16];
  int m_ph, m_integ, m_slow, m_fast, m_duty;
  bit m_vld;
  int a_gain, a_res, a_nl, a_dmax;

  function automatic int clamp_code(input int v);
    if (v < 1) return 1;
    if (v > 4) return 4;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) begin m_hist[i] = 0; m_seen[i] = 0; end
      m_ph = 0; m_integ = 0; m_slow = 0; m_fast = 0; m_duty = 0; m_vld = 0;
      a_gain = 0; a_res = 0; a_nl = 1; a_dmax = 0;
    end else begin
      m_vld = smp_vld;
      if (smp_vld) begin
        int g, r, dm, n, idx, e, filt, inc, base, s;
        bit b;
        b = per_start;
        e = smp_err;
        if (b) begin
          a_gain = cfg_gain; a_res = cfg_resid; a_nl = clamp_code(int'(cfg_nlog2)); a_dmax = cfg_dmax;
        end
        g = a_gain; r = a_res; dm = a_dmax; n = 1 << a_nl;
        idx = b ? 0 : m_ph;
        filt = e - (m_seen[idx] ? m_hist[idx] : 0);
        m_hist[idx] = e; m_seen[idx] = 1;
        m_ph = (idx + 1) % n;
        inc = (g * filt) >>> 4;
        if (b) begin
          m_integ = m_integ + e;
          if (m_integ > 32767) m_integ = 32767;
          if (m_integ < -32768) m_integ = -32768;
          base = ((m_duty - m_slow) * r) >>> 8;
          m_slow = ((g * e) >>> 4) + (m_integ >>> 2);
          m_fast = base + inc;
        end else begin
          m_fast = m_fast + inc;
        end
        s = m_slow + m_fast;
        m_duty = (s < 0) ? 0 : ((s > dm) ? dm : s);
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(int'(duty_cmd) == m_duty, "R8 model duty", int'(duty_cmd), m_duty);
      chk(duty_vld == m_vld, "R2 model valid", int'(duty_vld), int'(m_vld));
    end
  end

  task automatic tick(input int e, input bit ps);
    @(negedge clk);
    smp_vld = 1'b1; smp_err = 12'(e); per_start = ps;
    @(negedge clk);
    smp_vld = 1'b0; per_start = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(duty_cmd == '0, "R1 reset duty", int'(duty_cmd), 0);
    chk(duty_vld == 1'b0, "R1 reset valid", int'(duty_vld), 0);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    do_reset();

    // ---- first periods after reset, hand-computed ----
    cfg_gain = 8'd16; cfg_resid = 8'd0; cfg_nlog2 = 3'd2; cfg_dmax = 12'd4095;
    tick(160, 1);
    chk(duty_cmd == 12'd360, "R1 empty history first sample", int'(duty_cmd), 360);
    tick(160, 0);
    chk(duty_cmd == 12'd520, "R4 fast path next tick", int'(duty_cmd), 520);
    @(negedge clk);
    chk(duty_vld == 1'b0 && duty_cmd == 12'd520, "R2 idle hold", int'(duty_cmd), 520);
    tick(160, 0); tick(160, 0);
    tick(160, 1);
    chk(duty_cmd == 12'd240, "R7 residual zero cancel", int'(duty_cmd), 240);
    tick(160, 0); tick(160, 0);
    chk(duty_cmd == 12'd240, "R3 periodic input rejected", int'(duty_cmd), 240);
    tick(160, 0);
    tick(160, 1); tick(160, 0);
    tick(260, 0);
    chk(duty_cmd == 12'd380, "R3 step passes", int'(duty_cmd), 380);
    tick(160, 0);
    cfg_resid = 8'd128;
    tick(160, 1);
    chk(duty_cmd == 12'd370, "R7 half decay", int'(duty_cmd), 370);
    tick(160, 0); tick(160, 0); tick(160, 0);

    // ---- windup, clamp and config capture ----
    do_reset();
    cfg_gain = 8'd0; cfg_resid = 8'd0; cfg_nlog2 = 3'd1; cfg_dmax = 12'd1000;
    for (int p = 0; p < 20; p++) begin tick(-2048, 1); tick(-2048, 0); end
    chk(duty_cmd == 12'd0, "R8 low clamp", int'(duty_cmd), 0);
    for (int p = 0; p < 16; p++) begin tick(2047, 1); tick(2047, 0); end
    tick(2047, 1);
    chk(duty_cmd == 12'd507, "R6 integrator clamp recovery", int'(duty_cmd), 507);
    cfg_gain = 8'd255;
    tick(-2048, 0);
    chk(duty_cmd == 12'd507, "R9 mid-period gain ignored", int'(duty_cmd), 507);
    chk(duty_cmd == 12'd507, "R5 slow held between strobes", int'(duty_cmd), 507);
    cfg_gain = 8'd0;
    tick(2047, 1);
    chk(duty_cmd == 12'd1000, "R8 high clamp", int'(duty_cmd), 1000);

    // ---- missing strobes and ratio codes ----
    cfg_gain = 8'd16; cfg_resid = 8'd64; cfg_nlog2 = 3'd3; cfg_dmax = 12'd4095;
    tick(100, 1);
    for (int k = 0; k < 30; k++) tick((k % 5) * 40 - 80, 0);
    chk(int'(duty_cmd) == m_duty, "R10 wrap without strobe", int'(duty_cmd), m_duty);
    cfg_nlog2 = 3'd0;
    tick(50, 1);
    for (int k = 0; k < 9; k++) tick((k % 3) * 30, 0);
    chk(int'(duty_cmd) == m_duty, "R10 code zero clamps", int'(duty_cmd), m_duty);
    cfg_nlog2 = 3'd7;
    tick(-30, 1);
    for (int k = 0; k < 20; k++) tick(k * 7 - 60, 0);
    chk(int'(duty_cmd) == m_duty, "R10 code seven clamps", int'(duty_cmd), m_duty);

    // ---- pseudo-random traffic under several settings ----
    for (int c = 0; c < 3; c++) begin
      int nn;
      case (c)
        0: begin cfg_gain = 8'd40;  cfg_resid = 8'd200; cfg_nlog2 = 3'd2; cfg_dmax = 12'd3000; end
        1: begin cfg_gain = 8'd255; cfg_resid = 8'd255; cfg_nlog2 = 3'd4; cfg_dmax = 12'd4095; end
        default: begin cfg_gain = 8'd8; cfg_resid = 8'd30; cfg_nlog2 = 3'd1; cfg_dmax = 12'd500; end
      endcase
      nn = 1 << int'(cfg_nlog2);
      for (int k = 0; k < 320; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tick(int'($signed(lfsr[11:0])) >>> (c == 1 ? 0 : 3), (k % nn) == 0 && (k % 97) != 0);
      end
      chk(int'(duty_cmd) == m_duty, "R9 random settings", int'(duty_cmd), m_duty);
    end

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule